// File: doc/BRIEF.md
# Ethernet Transmit Pause and Graceful-Stop Controller

This block decides, at every frame boundary of a full-duplex Ethernet transmit path, whether the next frame sent is a queued data frame, a locally built MAC Control PAUSE frame, or nothing. Software controls it through two register bits. A level-sensitive graceful-stop bit halts data traffic. A pause-send bit, set by a write pulse, asks for one PAUSE frame. The receive side reports each PAUSE frame it sees, together with the quanta carried in that frame. The block counts that duration down and keeps data frames halted until it expires.

The transmit engine reports the end of each data frame, either as a normal completion or as an early collision. The controller tracks whether a data frame is in flight, so a halt only takes effect at a frame boundary. A single-cycle stop-complete pulse marks the moment a halt takes hold. When a PAUSE frame is granted, the block streams its 60 header and payload bytes one per clock. The FCS is appended downstream.

Top module: `eth_pause_ctrl`

## Requirements
- R1: While the graceful-stop input is high, no `data_start` is issued once the frame in flight has ended (`tx_done` or `tx_coll`). `stop_irq` pulses only after that frame has ended, never while it is still in flight.
- R2: If graceful stop rises while no frame is in flight and no pause-send request is pending, `stop_irq` is high in the clock cycle right after the first rising edge that samples the stop input high.
- R3: `stop_irq` is one cycle wide. It pulses once per halt episode and does not pulse again while a graceful-stop or pause-send halt stays in force, including while a PAUSE frame is sent during a graceful stop.
- R4: When graceful stop falls, data transmission resumes: `data_start` is issued for the waiting frame within three cycles.
- R5: An early collision (`tx_coll`) ends the data frame in flight and marks it for resending. The resend is granted with `data_retry` high alongside `data_start`, even when `data_ready` is low. With graceful stop high, the resend waits until the stop falls.
- R6: A `cfg_pause_set` pulse sets `pause_tx_pend`. No PAUSE frame starts while a data frame is in flight. At the next boundary `stop_irq` pulses and the PAUSE frame is sent. `pause_tx_pend` clears once its last byte is out, and only after that are data frames granted again.
- R7: A PAUSE frame is granted while data frames are halted, whether by graceful stop or by a received pause.
- R8: When a pending PAUSE request and a ready data frame meet at the same boundary, the PAUSE frame is granted first. `data_start` and `pause_start` are never high together.
- R9: A granted PAUSE frame is 60 bytes long and is streamed on consecutive cycles. `pause_byte_valid` is high for the whole frame, and the first byte appears in the same cycle as `pause_start`. The byte order is:
  - destination 01 80 C2 00 00 01;
  - `station_addr_lo` bits 31:24, 23:16, 15:8, 7:0;
  - `station_addr_hi` bits 15:8, 7:0;
  - type 88 08;
  - opcode 00 01;
  - the `cfg_pause_quanta` high byte, then its low byte, both captured at the grant;
  - 42 zero bytes.
  
  `pause_byte_last` marks byte 59.
- R10: A `rx_pause_valid` pulse with nonzero quanta Q raises `rx_pause_flag` from the next cycle, for exactly Q × CYC_PER_QUANTUM cycles. No `data_start` is issued while the flag is high.
- R11: A new received pause while the flag is high reloads the countdown from the new quanta. A received quanta of zero clears `rx_pause_flag` in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_stop | input | 1 | Graceful-stop register bit (level) |
| cfg_pause_set | input | 1 | Write pulse that sets the pause-send bit |
| cfg_pause_quanta | input | 16 | Quanta placed in transmitted PAUSE frames |
| station_addr_lo | input | 32 | Source address bytes 0..3 (byte 0 in bits 31:24) |
| station_addr_hi | input | 16 | Source address bytes 4..5 (byte 4 in bits 15:8) |
| data_ready | input | 1 | A data frame waits in the transmit queue |
| tx_done | input | 1 | Data frame in flight completed |
| tx_coll | input | 1 | Data frame in flight aborted by early collision |
| rx_pause_valid | input | 1 | A PAUSE frame was received |
| rx_pause_quanta | input | 16 | Quanta carried by the received PAUSE frame |
| data_start | output | 1 | Grant pulse: start the next data frame |
| data_retry | output | 1 | With `data_start`: the grant is a resend after collision |
| pause_start | output | 1 | Grant pulse: a PAUSE frame starts |
| pause_byte_valid | output | 1 | A PAUSE frame byte is on `pause_byte` |
| pause_byte | output | 8 | PAUSE frame byte |
| pause_byte_last | output | 1 | Final PAUSE frame byte (before FCS) |
| stop_irq | output | 1 | Stop-complete interrupt pulse |
| pause_tx_pend | output | 1 | Self-clearing pause-send bit |
| rx_pause_flag | output | 1 | Received pause in force |

## Verification
The hardest situation to reach is one where several halt sources overlap. Examples are a PAUSE request raised during a graceful stop, or while a received pause is counting down, because the interrupt must stay silent while the PAUSE frame still goes out. The stimulus holds the stop bit, or starts a long received pause, before pulsing the pause-send bit. It then counts grants and interrupt pulses over the whole frame. Collision resends are reached by aborting a frame with the stop bit raised and dropping `data_ready`, so that only the resend mark can cause the later grant.

// File: rtl/epc_pkg.sv
package epc_pkg;

    typedef enum logic [1:0] {
        ARB_IDLE  = 2'd0,
        ARB_DATA  = 2'd1,
        ARB_PAUSE = 2'd2
    } arb_state_e;

    typedef struct packed {
        arb_state_e state;
        logic       pause_tx;
        logic       retry;
        logic       halt_prev;
        logic       irq;
        logic       data_start;
        logic       retry_out;
        logic       pause_start;
    } arb_regs_t;

    localparam int PAUSE_FRAME_BYTES = 60;

endpackage

// File: rtl/epc_rx_timer.sv
module epc_rx_timer #(
    parameter int QUANTA_W        = 16,
    parameter int CYC_PER_QUANTUM = 64
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                rx_valid,
    input  logic [QUANTA_W-1:0] rx_quanta,
    output logic                active
);

    localparam int SUB_W = (CYC_PER_QUANTUM > 1) ? $clog2(CYC_PER_QUANTUM) : 1;
    localparam logic [SUB_W-1:0] SUB_TOP = SUB_W'(CYC_PER_QUANTUM - 1);

    typedef struct packed {
        logic [QUANTA_W-1:0] cnt;
        logic [SUB_W-1:0]    sub;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        if (rx_valid) begin
            tmr_d.cnt = rx_quanta;
            tmr_d.sub = SUB_TOP;
        end else if (tmr_q.cnt != '0) begin
            if (tmr_q.sub == '0) begin
                tmr_d.cnt = tmr_q.cnt - 1'b1;
                tmr_d.sub = SUB_TOP;
            end else begin
                tmr_d.sub = tmr_q.sub - 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) tmr_q <= '0;
        else        tmr_q <= tmr_d;
    end

    assign active = (tmr_q.cnt != '0);

    AST_ZERO_QUANTA_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && rx_quanta == '0) |=> !active); // R11
    AST_LOAD_RAISES_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && rx_quanta != '0) |=> active); // R10

endmodule

// File: rtl/epc_frame_gen.sv
module epc_frame_gen #(
    parameter int FRAME_BYTES = epc_pkg::PAUSE_FRAME_BYTES
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        go,
    input  logic [15:0] quanta,
    input  logic [31:0] addr_lo,
    input  logic [15:0] addr_hi,
    output logic        byte_valid,
    output logic [7:0]  byte_out,
    output logic        byte_last
);

    localparam int IDX_W = $clog2(FRAME_BYTES);
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(FRAME_BYTES - 1);

    typedef struct packed {
        logic             active;
        logic [IDX_W-1:0] idx;
        logic [15:0]      quanta;
    } gen_t;

    gen_t gen_d, gen_q;
    logic [7:0] sel_byte;

    always_comb begin
        gen_d = gen_q;
        if (go) begin
            gen_d.active = 1'b1;
            gen_d.idx    = '0;
            gen_d.quanta = quanta;
        end else if (gen_q.active) begin
            if (gen_q.idx == IDX_LAST) gen_d.active = 1'b0;
            else                       gen_d.idx    = gen_q.idx + 1'b1;
        end
    end

    always_comb begin
        case (int'(gen_q.idx))
            0:       sel_byte = 8'h01;
            1:       sel_byte = 8'h80;
            2:       sel_byte = 8'hC2;
            3:       sel_byte = 8'h00;
            4:       sel_byte = 8'h00;
            5:       sel_byte = 8'h01;
            6:       sel_byte = addr_lo[31:24];
            7:       sel_byte = addr_lo[23:16];
            8:       sel_byte = addr_lo[15:8];
            9:       sel_byte = addr_lo[7:0];
            10:      sel_byte = addr_hi[15:8];
            11:      sel_byte = addr_hi[7:0];
            12:      sel_byte = 8'h88;
            13:      sel_byte = 8'h08;
            14:      sel_byte = 8'h00;
            15:      sel_byte = 8'h01;
            16:      sel_byte = gen_q.quanta[15:8];
            17:      sel_byte = gen_q.quanta[7:0];
            default: sel_byte = 8'h00;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) gen_q <= '0;
        else        gen_q <= gen_d;
    end

    assign byte_valid = gen_q.active;
    assign byte_out   = gen_q.active ? sel_byte : 8'h00;
    assign byte_last  = gen_q.active && (gen_q.idx == IDX_LAST);

    AST_FIRST_BYTE_DA: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(byte_valid) |-> (byte_out == 8'h01)); // R9
    AST_BYTES_CONTIGUOUS: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_valid && !byte_last) |=> byte_valid); // R9

endmodule

// File: rtl/epc_arbiter.sv
module epc_arbiter
    import epc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cfg_stop,
    input  logic cfg_pause_set,
    input  logic data_ready,
    input  logic tx_done,
    input  logic tx_coll,
    input  logic rx_pause_active,
    input  logic gen_last,
    output logic gen_go,
    output logic data_start,
    output logic data_retry,
    output logic pause_start,
    output logic stop_irq,
    output logic pause_tx_pend
);

    arb_regs_t arb_d, arb_q;
    logic data_halt;
    logic halt_eff;

    always_comb begin
        arb_d             = arb_q;
        arb_d.irq         = 1'b0;
        arb_d.data_start  = 1'b0;
        arb_d.retry_out   = 1'b0;
        arb_d.pause_start = 1'b0;
        gen_go            = 1'b0;

        data_halt = cfg_stop | arb_q.pause_tx | rx_pause_active;
        halt_eff  = (cfg_stop | arb_q.pause_tx) && (arb_q.state != ARB_DATA);

        arb_d.halt_prev = halt_eff;
        arb_d.irq       = halt_eff & ~arb_q.halt_prev;

        if (cfg_pause_set) arb_d.pause_tx = 1'b1;

        case (arb_q.state)
            ARB_IDLE: begin
                if (arb_q.pause_tx) begin
                    arb_d.state       = ARB_PAUSE;
                    arb_d.pause_start = 1'b1;
                    gen_go            = 1'b1;
                end else if ((data_ready | arb_q.retry) && !data_halt) begin
                    arb_d.state      = ARB_DATA;
                    arb_d.data_start = 1'b1;
                    arb_d.retry_out  = arb_q.retry;
                    arb_d.retry      = 1'b0;
                end
            end
            ARB_DATA: begin
                if (tx_coll) begin
                    arb_d.retry = 1'b1;
                    arb_d.state = ARB_IDLE;
                end else if (tx_done) begin
                    arb_d.state = ARB_IDLE;
                end
            end
            ARB_PAUSE: begin
                if (gen_last) begin
                    arb_d.state = ARB_IDLE;
                    if (!cfg_pause_set) arb_d.pause_tx = 1'b0;
                end
            end
            default: arb_d.state = ARB_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) arb_q <= '0;
        else        arb_q <= arb_d;
    end

    assign data_start    = arb_q.data_start;
    assign data_retry    = arb_q.retry_out;
    assign pause_start   = arb_q.pause_start;
    assign stop_irq      = arb_q.irq;
    assign pause_tx_pend = arb_q.pause_tx;

    AST_START_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(data_start && pause_start)); // R8
    AST_HALT_BLOCKS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        data_start |-> ($past(!cfg_stop) && $past(!rx_pause_active))); // R1
    AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        stop_irq |=> !stop_irq); // R3
    AST_PAUSE_BIT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pause_tx_pend) |-> $past(gen_last)); // R6

endmodule

// File: rtl/eth_pause_ctrl.sv
module eth_pause_ctrl #(
    parameter int QUANTA_W        = 16,
    parameter int CYC_PER_QUANTUM = 64
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_stop,
    input  logic        cfg_pause_set,
    input  logic [15:0] cfg_pause_quanta,
    input  logic [31:0] station_addr_lo,
    input  logic [15:0] station_addr_hi,
    input  logic        data_ready,
    input  logic        tx_done,
    input  logic        tx_coll,
    input  logic        rx_pause_valid,
    input  logic [15:0] rx_pause_quanta,
    output logic        data_start,
    output logic        data_retry,
    output logic        pause_start,
    output logic        pause_byte_valid,
    output logic [7:0]  pause_byte,
    output logic        pause_byte_last,
    output logic        stop_irq,
    output logic        pause_tx_pend,
    output logic        rx_pause_flag
);

    logic gen_go;

    epc_rx_timer #(
        .QUANTA_W       (QUANTA_W),
        .CYC_PER_QUANTUM(CYC_PER_QUANTUM)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .rx_valid (rx_pause_valid),
        .rx_quanta(QUANTA_W'(rx_pause_quanta)),
        .active   (rx_pause_flag)
    );

    epc_frame_gen #(
        .FRAME_BYTES(epc_pkg::PAUSE_FRAME_BYTES)
    ) u_gen (
        .clk       (clk),
        .rst_n     (rst_n),
        .go        (gen_go),
        .quanta    (cfg_pause_quanta),
        .addr_lo   (station_addr_lo),
        .addr_hi   (station_addr_hi),
        .byte_valid(pause_byte_valid),
        .byte_out  (pause_byte),
        .byte_last (pause_byte_last)
    );

    epc_arbiter u_arb (
        .clk            (clk),
        .rst_n          (rst_n),
        .cfg_stop       (cfg_stop),
        .cfg_pause_set  (cfg_pause_set),
        .data_ready     (data_ready),
        .tx_done        (tx_done),
        .tx_coll        (tx_coll),
        .rx_pause_active(rx_pause_flag),
        .gen_last       (pause_byte_last),
        .gen_go         (gen_go),
        .data_start     (data_start),
        .data_retry     (data_retry),
        .pause_start    (pause_start),
        .stop_irq       (stop_irq),
        .pause_tx_pend  (pause_tx_pend)
    );

    AST_GRANT_NOT_DURING_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        pause_start |-> !$past(pause_byte_valid && !pause_byte_last)); // R9

endmodule

// File: tb/eth_pause_ctrl_tb.sv
module eth_pause_ctrl_tb;

    localparam int CPQ = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_stop = 1'b0;
    logic        cfg_pause_set = 1'b0;
    logic [15:0] cfg_pause_quanta = '0;
    logic [31:0] station_addr_lo = '0;
    logic [15:0] station_addr_hi = '0;
    logic        data_ready = 1'b0;
    logic        tx_done = 1'b0;
    logic        tx_coll = 1'b0;
    logic        rx_pause_valid = 1'b0;
    logic [15:0] rx_pause_quanta = '0;
    logic        data_start, data_retry, pause_start;
    logic        pause_byte_valid, pause_byte_last;
    logic [7:0]  pause_byte;
    logic        stop_irq, pause_tx_pend, rx_pause_flag;

    eth_pause_ctrl #(.QUANTA_W(16), .CYC_PER_QUANTUM(CPQ)) u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_stop(cfg_stop), .cfg_pause_set(cfg_pause_set),
        .cfg_pause_quanta(cfg_pause_quanta), .station_addr_lo(station_addr_lo),
        .station_addr_hi(station_addr_hi), .data_ready(data_ready), .tx_done(tx_done),
        .tx_coll(tx_coll), .rx_pause_valid(rx_pause_valid), .rx_pause_quanta(rx_pause_quanta),
        .data_start(data_start), .data_retry(data_retry), .pause_start(pause_start),
        .pause_byte_valid(pause_byte_valid), .pause_byte(pause_byte),
        .pause_byte_last(pause_byte_last), .stop_irq(stop_irq),
        .pause_tx_pend(pause_tx_pend), .rx_pause_flag(rx_pause_flag)
    );

    always #4 clk = ~clk;

    int n_checks = 0, n_fail = 0;
    int cyc = 0;
    int n_data, n_pause, n_irq, n_flag, n_bytes, last_retry;
    int first_data_cyc, first_pause_cyc, last_byte_cyc;
    logic [7:0] bytes [0:63];

    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            if (data_start) begin
                n_data++;
                last_retry = int'(data_retry);
                if (first_data_cyc < 0) first_data_cyc = cyc;
            end
            if (pause_start) begin
                n_pause++;
                if (first_pause_cyc < 0) first_pause_cyc = cyc;
            end
            if (stop_irq) n_irq++;
            if (rx_pause_flag) n_flag++;
            if (pause_byte_valid) begin
                if (n_bytes < 64) bytes[n_bytes] = pause_byte;
                n_bytes++;
            end
            if (pause_byte_last) last_byte_cyc = cyc;
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic clr();
        n_data = 0; n_pause = 0; n_irq = 0; n_flag = 0; n_bytes = 0; last_retry = -1;
        first_data_cyc = -1; first_pause_cyc = -1; last_byte_cyc = -1;
    endtask

    task automatic waitc(input int n);
        repeat (n) begin @(posedge clk); #1; end
    endtask

    task automatic pulse_done();  tx_done = 1'b1; waitc(1); tx_done = 1'b0; endtask
    task automatic pulse_coll();  tx_coll = 1'b1; waitc(1); tx_coll = 1'b0; endtask
    task automatic pulse_pause(); cfg_pause_set = 1'b1; waitc(1); cfg_pause_set = 1'b0; endtask
    task automatic pulse_rx(input int q);
        rx_pause_quanta = 16'(q); rx_pause_valid = 1'b1; waitc(1); rx_pause_valid = 1'b0;
    endtask

    function automatic logic [7:0] exp_byte(input int i, input logic [31:0] lo,
                                           input logic [15:0] hi, input logic [15:0] q);
        logic [7:0] da [0:5];
        da[0] = 8'h01; da[1] = 8'h80; da[2] = 8'hC2; da[3] = 8'h00; da[4] = 8'h00; da[5] = 8'h01;
        if (i < 6)   return da[i];
        if (i < 10)  return lo[8*(9-i) +: 8];
        if (i < 12)  return hi[8*(11-i) +: 8];
        if (i == 12) return 8'h88;
        if (i == 13) return 8'h08;
        if (i == 14) return 8'h00;
        if (i == 15) return 8'h01;
        if (i < 18)  return q[8*(17-i) +: 8];
        return 8'h00;
    endfunction

    task automatic check_frame();
        check(n_bytes == 60, "R9 frame length", n_bytes, 60);
        for (int i = 0; i < 60; i++)
            check(bytes[i] == exp_byte(i, station_addr_lo, station_addr_hi, cfg_pause_quanta),
                  $sformatf("R9 byte %0d", i), int'(bytes[i]),
                  int'(exp_byte(i, station_addr_lo, station_addr_hi, cfg_pause_quanta)));
    endtask

    always @(posedge clk) begin
        if (cyc > 150000) begin
            n_fail++; n_checks++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        clr();
        waitc(5);
        check(!data_start && !pause_start && !stop_irq, "R3 reset quiet", int'(stop_irq), 0);
        check(!pause_tx_pend, "R6 reset pause bit", int'(pause_tx_pend), 0);
        check(!rx_pause_flag, "R10 reset flag", int'(rx_pause_flag), 0);
        rst_n = 1'b1;
        waitc(2);

        // R1, R3, R4: graceful stop during a data frame
        clr(); data_ready = 1'b1; waitc(3);
        check(n_data == 1, "R4 first data grant", n_data, 1);
        data_ready = 1'b0; cfg_stop = 1'b1; clr(); waitc(5);
        check(n_irq == 0, "R1 no irq while frame in flight", n_irq, 0);
        pulse_done(); waitc(5);
        check(n_irq == 1, "R1 irq after frame ends", n_irq, 1);
        data_ready = 1'b1; waitc(20);
        check(n_data == 0, "R1 no data grant while stopped", n_data, 0);
        check(n_irq == 1, "R3 no repeat irq", n_irq, 1);
        cfg_stop = 1'b0; clr(); waitc(3);
        check(n_data == 1, "R4 resume after stop clear", n_data, 1);
        check(last_retry == 0, "R5 fresh frame not retry", last_retry, 0);
        data_ready = 1'b0; pulse_done(); waitc(3);

        // R2: stop while idle
        clr(); cfg_stop = 1'b1; waitc(1);
        check(stop_irq == 1'b1, "R2 immediate irq", int'(stop_irq), 1);
        waitc(10);
        check(n_irq == 1, "R3 single pulse", n_irq, 1);

        // R7, R3, R9: pause frame during graceful stop
        station_addr_lo = 32'h1234_5678; station_addr_hi = 16'h9ABC; cfg_pause_quanta = 16'h00FF;
        clr(); pulse_pause(); waitc(70);
        check(n_pause == 1, "R7 pause sent under stop", n_pause, 1);
        check(n_irq == 0, "R3 no irq for pause under stop", n_irq, 0);
        check(n_data == 0, "R1 no data under stop", n_data, 0);
        check(!pause_tx_pend, "R6 pause bit self-clears", int'(pause_tx_pend), 0);
        check_frame();
        cfg_stop = 1'b0; waitc(3);

        // R5: collision with stop set
        clr(); data_ready = 1'b1; waitc(3); data_ready = 1'b0;
        cfg_stop = 1'b1; clr(); pulse_coll(); waitc(10);
        check(n_data == 0, "R5 no resend while stopped", n_data, 0);
        check(n_irq == 1, "R1 irq after collision", n_irq, 1);
        cfg_stop = 1'b0; waitc(3);
        check(n_data == 1, "R5 resend after stop clear", n_data, 1);
        check(last_retry == 1, "R5 retry flag", last_retry, 1);
        pulse_done(); waitc(3);

        // R5: collision without stop
        clr(); data_ready = 1'b1; waitc(3); data_ready = 1'b0;
        clr(); pulse_coll(); waitc(4);
        check(n_data == 1, "R5 immediate resend", n_data, 1);
        check(last_retry == 1, "R5 resend marked", last_retry, 1);
        check(n_irq == 0, "R3 no irq without halt", n_irq, 0);
        pulse_done(); waitc(3);

        // R6, R8, R9: pause request during a data frame
        station_addr_lo = 32'hA1B2_C3D4; station_addr_hi = 16'hE5F6; cfg_pause_quanta = 16'h1234;
        data_ready = 1'b1; waitc(3); clr();
        pulse_pause(); waitc(5);
        check(n_pause == 0, "R6 pause waits for frame end", n_pause, 0);
        check(pause_tx_pend == 1'b1, "R6 pause bit set", int'(pause_tx_pend), 1);
        pulse_done(); waitc(75);
        check(n_irq == 1, "R6 irq at boundary", n_irq, 1);
        check(n_pause == 1, "R6 pause sent", n_pause, 1);
        check(first_pause_cyc >= 0 && first_pause_cyc < first_data_cyc, "R8 pause before data",
              first_pause_cyc, first_data_cyc);
        check(first_data_cyc > last_byte_cyc, "R6 data resumes after pause", first_data_cyc, last_byte_cyc);
        check(!pause_tx_pend, "R6 bit cleared", int'(pause_tx_pend), 0);
        check_frame();
        data_ready = 1'b0; pulse_done(); waitc(3);

        // R7, R10: pause frame while a received pause holds data
        station_addr_lo = 32'h0F0E_0D0C; station_addr_hi = 16'h0B0A; cfg_pause_quanta = 16'hFFFF;
        clr(); pulse_rx(30); data_ready = 1'b1; pulse_pause(); waitc(70);
        check(n_pause == 1, "R7 pause sent under rx pause", n_pause, 1);
        check(n_data == 0, "R10 data held by rx pause", n_data, 0);
        check_frame();
        waitc(60);
        check(n_data == 1, "R10 data after rx pause expires", n_data, 1);
        data_ready = 1'b0; pulse_done(); waitc(3);

        // R10: duration sweep
        for (int q = 1; q <= 8; q++) begin
            clr(); pulse_rx(q); waitc(q * CPQ + 5);
            check(n_flag == q * CPQ, $sformatf("R10 duration q=%0d", q), n_flag, q * CPQ);
        end

        // R11: reload and zero
        clr(); pulse_rx(5); waitc(6); pulse_rx(3); waitc(30);
        check(n_flag == 7 + 3 * CPQ, "R11 reload", n_flag, 7 + 3 * CPQ);
        clr(); pulse_rx(4); waitc(3); pulse_rx(0); waitc(20);
        check(n_flag == 4, "R11 zero ends pause", n_flag, 4);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule